// File: doc/BRIEF.md
# Tapered-Window One-Bit Stream Sampler

This block turns several one-bit sigma-delta ADC streams into 8-bit samples at the full input bit rate. Each lane keeps the most recent 45 bits it has accepted. On every accepted bit, the lane adds a fixed weight for each set bit in that history. The weights form a tapered (Tukey) window: the ends ramp up, the centre is flat, and the weights sum to 1023. The result is an 8-bit value in which an all-ones window reads 255 and an all-zeros window reads 0. There is no decimation, so one new sample can leave each lane on every clock. This suits a capture front end that records a few channels side by side at full speed.

The lanes are identical and fully independent. Each lane has its own bit, its own qualifier and its own output valid. The weighted sum is split over two register stages, so the adder depth per clock stays small. The output therefore follows the accepted bit by a fixed number of clocks.

Top module: `tukey_scope_filter`

## Requirements
- R1: While `rst` is high at a rising clock edge, every lane's history, pipeline and output are cleared: from the next clock on, `sampleOut` is all zeros and `sampleValid` is all zeros.
- R2: `sampleValid[l]` is high in exactly the clock cycle that starts three rising edges after an edge at which `bitValid[l]` was high (three register stages), and low otherwise.
- R3: The sample is formed from the window sum S = sum of w(i) over each set history bit i. Tap 0 is the most recently accepted bit. The weights from tap 0 to tap 44 are: 1,3,5,7,10,13,16,19,22,25,27,29,31, then nine taps of 32, then 31 (tap 22), then nine taps of 32, then 31,29,27,25,22,19,16,13,10,7,5,3,1.
- R4: After 45 or more consecutive accepted ones, a lane outputs 255 (S = 1023).
- R5: `sampleOut` is bits 9 down to 2 of S; the two low bits are dropped. For example, S = 1 gives 0 and S = 4 gives 1.
- R6: Lane l uses only `bitIn[l]` and `bitValid[l]`, and drives only `sampleOut[8l+7:8l]` and `sampleValid[l]`. Other lanes' inputs have no effect on it.
- R7: A clock edge with `bitValid[l]` low does not shift lane l's history. Three clocks later, the lane's `sampleOut` keeps its previous value and its `sampleValid` is low.
- R8: With `bitValid[l]` high on every clock, lane l produces a valid sample on every clock, with no decimation.
- R9: After reset the history holds zeros. The first k accepted bits after reset are weighted by taps 0..k-1 only (for example, k ones give the sum of the first k weights).
- R10: An accepted bit affects the output for exactly 45 accepted bits. After 45 accepted zeros, the lane outputs 0 whatever came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bitIn | input | LANES | One ADC bit per lane |
| bitValid | input | LANES | Per-lane qualifier; high means bitIn[l] is accepted this clock |
| sampleOut | output | LANES*OUT_W | Per-lane 8-bit sample, lane l in bits [8l+7:8l] |
| sampleValid | output | LANES | Per-lane sample strobe, bitValid delayed by three clocks |

## Verification
The result for a bit accepted at a given edge is due in the cycle that follows the third rising edge from that one. The checker states this as a three-cycle `$past` relation for the strobe, the hold behaviour and the full-scale value. The bench keeps a three-deep queue of expected samples and valids, computed from its own copy of the weight list. Each new expectation enters the queue when its stimulus is driven and is compared three falling edges later, so every comparison sits half a clock away from the edge that updated the output. Resets flush the queue, and their zero outputs are checked directly while reset is still held.

// File: rtl/tukey_pkg.sv
package tukey_pkg;

  // Fixed tapered window: ramp length, total length and arithmetic widths.
  localparam int TAPS     = 45;
  localparam int RAMP     = 13;
  localparam int WEIGHT_W = 6;
  localparam int SUM_W    = 10;

  // Strobes the lane control hands to one lane datapath.
  typedef struct packed {
    logic shiftEn;   // accept bitIn into the history this clock
    logic grpLoad;   // capture the partial (group) sums
    logic sumLoad;   // capture the final window sum
  } laneStrobe_t;

  // Weight of the k-th tap counted from either end of the ramp.
  function automatic logic [WEIGHT_W-1:0] rampWeight(input int k);
    logic [WEIGHT_W-1:0] w;
    case (k)
      0:  w = 6'd1;
      1:  w = 6'd3;
      2:  w = 6'd5;
      3:  w = 6'd7;
      4:  w = 6'd10;
      5:  w = 6'd13;
      6:  w = 6'd16;
      7:  w = 6'd19;
      8:  w = 6'd22;
      9:  w = 6'd25;
      10: w = 6'd27;
      11: w = 6'd29;
      12: w = 6'd31;
      default: w = 6'd32;
    endcase
    return w;
  endfunction

  // Weight of history tap idx (tap 0 is the newest bit); symmetric window.
  function automatic logic [WEIGHT_W-1:0] tapWeight(input int idx);
    int fromEdge;
    logic [WEIGHT_W-1:0] w;
    fromEdge = (idx < TAPS - 1 - idx) ? idx : TAPS - 1 - idx;
    if (fromEdge < RAMP)       w = rampWeight(fromEdge);
    else if (idx == TAPS / 2)  w = 6'd31;   // centre tap trimmed so the total is 1023
    else                       w = 6'd32;
    return w;
  endfunction

endpackage

// File: rtl/tukey_ctrl.sv
module tukey_ctrl
  import tukey_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [LANES-1:0]              bitValid,
  output laneStrobe_t [LANES-1:0]       strobes,
  output logic [LANES-1:0]              sampleValid
);

  // Per-lane qualifier pipeline, one flop per datapath stage.
  logic [LANES-1:0] validHist;
  logic [LANES-1:0] validGrp;
  logic [LANES-1:0] validSum;

  always_ff @(posedge clk) begin
    if (rst) begin
      validHist <= '0;
      validGrp  <= '0;
      validSum  <= '0;
    end else begin
      validHist <= bitValid;
      validGrp  <= validHist;
      validSum  <= validGrp;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_strobe
    always_comb begin
      strobes[l].shiftEn = bitValid[l];
      strobes[l].grpLoad = validHist[l];
      strobes[l].sumLoad = validGrp[l];
    end
  end

  assign sampleValid = validSum;

endmodule

// File: rtl/tukey_lane_dp.sv
module tukey_lane_dp
  import tukey_pkg::*;
#(
  parameter int GROUP_SIZE = 8,
  parameter int OUT_W      = 8,
  parameter int SHIFT      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bitIn,
  input  laneStrobe_t      strobe,
  output logic [OUT_W-1:0] sampleOut
);

  localparam int NGRP = (TAPS + GROUP_SIZE - 1) / GROUP_SIZE;

  logic [TAPS-1:0]  histQ;
  logic [SUM_W-1:0] grpNext [NGRP];
  logic [SUM_W-1:0] grpQ    [NGRP];
  logic [SUM_W-1:0] sumNext;
  logic [OUT_W-1:0] sampleQ;

  // History: newest bit enters at tap 0.
  always_ff @(posedge clk) begin
    if (rst)                 histQ <= '0;
    else if (strobe.shiftEn) histQ <= {histQ[TAPS-2:0], bitIn};
  end

  // Stage 1: fixed-weight partial sums over groups of taps.
  for (genvar g = 0; g < NGRP; g++) begin : g_group
    always_comb begin
      grpNext[g] = '0;
      for (int j = 0; j < GROUP_SIZE; j++) begin
        if (g * GROUP_SIZE + j < TAPS) begin
          if (histQ[g * GROUP_SIZE + j])
            grpNext[g] = grpNext[g] + SUM_W'(tapWeight(g * GROUP_SIZE + j));
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst)                 grpQ[g] <= '0;
      else if (strobe.grpLoad) grpQ[g] <= grpNext[g];
    end
  end

  // Stage 2: total of the group sums, scaled to the output field.
  always_comb begin
    sumNext = '0;
    for (int g = 0; g < NGRP; g++) sumNext = sumNext + grpQ[g];
  end

  always_ff @(posedge clk) begin
    if (rst)                 sampleQ <= '0;
    else if (strobe.sumLoad) sampleQ <= OUT_W'(sumNext >> SHIFT);
  end

  assign sampleOut = sampleQ;

endmodule

// File: rtl/tukey_scope_filter.sv
module tukey_scope_filter
  import tukey_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int GROUP_SIZE = 8,
  parameter int OUT_W      = 8,
  parameter int SHIFT      = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES-1:0]       bitIn,
  input  logic [LANES-1:0]       bitValid,
  output logic [LANES*OUT_W-1:0] sampleOut,
  output logic [LANES-1:0]       sampleValid
);

  laneStrobe_t [LANES-1:0] strobes;

  tukey_ctrl #(.LANES(LANES)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .bitValid    (bitValid),
    .strobes     (strobes),
    .sampleValid (sampleValid)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    tukey_lane_dp #(
      .GROUP_SIZE (GROUP_SIZE),
      .OUT_W      (OUT_W),
      .SHIFT      (SHIFT)
    ) u_dp (
      .clk       (clk),
      .rst       (rst),
      .bitIn     (bitIn[l]),
      .strobe    (strobes[l]),
      .sampleOut (sampleOut[l*OUT_W +: OUT_W])
    );
  end

endmodule

// File: rtl/tukey_scope_filter_chk.sv
module tukey_scope_filter_chk
  import tukey_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OUT_W = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [LANES-1:0]       bitIn,
  input logic [LANES-1:0]       bitValid,
  input logic [LANES*OUT_W-1:0] sampleOut,
  input logic [LANES-1:0]       sampleValid
);

  logic [2:0] sinceRst;
  logic       prevRst;

  always_ff @(posedge clk) begin
    if (rst)                  sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
  end

  // R1: one clock after a reset edge everything reads zero.
  always_ff @(posedge clk) begin
    prevRst <= rst;
    if (prevRst == 1'b1) begin
      p_reset_clear_r1: assert (sampleOut == '0 && sampleValid == '0)
        else $error("reset did not clear outputs");
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [5:0] onesRun;

    always_ff @(posedge clk) begin
      if (rst) onesRun <= '0;
      else if (bitValid[l])
        onesRun <= bitIn[l] ? ((onesRun == 6'd63) ? onesRun : onesRun + 6'd1) : 6'd0;
    end

    // R2: strobe is the qualifier three clocks late.
    p_valid_latency_r2: assert property (@(posedge clk) disable iff (rst)
      (sinceRst >= 3'd3) |-> (sampleValid[l] == $past(bitValid[l], 3)));

    // R7: an unqualified clock leaves the sample unchanged three clocks later.
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
      (sinceRst >= 3'd4 && !$past(bitValid[l], 3)) |-> $stable(sampleOut[l*OUT_W +: OUT_W]));

    // R4: a window full of ones reads full scale.
    p_full_scale_r4: assert property (@(posedge clk) disable iff (rst)
      (sinceRst >= 3'd3 && $past(onesRun, 2) >= 6'(TAPS)) |-> (sampleOut[l*OUT_W +: OUT_W] == '1));
  end

endmodule

bind tukey_scope_filter tukey_scope_filter_chk #(.LANES(LANES), .OUT_W(OUT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bitIn       (bitIn),
  .bitValid    (bitValid),
  .sampleOut   (sampleOut),
  .sampleValid (sampleValid)
);

// File: tb/test_tukey_scope_filter.sv
module test_tukey_scope_filter;

  localparam int LANES = 4;
  localparam int OUT_W = 8;
  localparam int TAPS  = 45;

  logic                   clk = 1'b0;
  logic                   rst;
  logic [LANES-1:0]       bitIn;
  logic [LANES-1:0]       bitValid;
  logic [LANES*OUT_W-1:0] sampleOut;
  logic [LANES-1:0]       sampleValid;

  always #2.5 clk = ~clk;

  tukey_scope_filter i_tukey_scope_filter (
    .clk(clk), .rst(rst), .bitIn(bitIn), .bitValid(bitValid),
    .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  // R3 weight list, tap 0 = newest bit.
  localparam int W [TAPS] = '{1,3,5,7,10,13,16,19,22,25,27,29,31,
                              32,32,32,32,32,32,32,32,32,31,32,32,32,32,32,32,32,32,32,
                              31,29,27,25,22,19,16,13,10,7,5,3,1};

  typedef struct packed {
    logic [3:0] bits;
    logic [3:0] valid;
    logic [7:0] reps;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{4'b1111, 4'b1111, 8'd50, 4'd4},   // R4 ramp to full scale, R8 every clock
    '{4'b0000, 4'b1111, 8'd50, 4'd10},  // R10 drain to zero
    '{4'b0001, 4'b1111, 8'd1,  4'd5},   // R5 sum 1 -> 0
    '{4'b0001, 4'b1111, 8'd1,  4'd5},   // R5 sum 4 -> 1
    '{4'b0000, 4'b1111, 8'd48, 4'd10},
    '{4'b0101, 4'b1111, 8'd30, 4'd6},   // R6 lanes differ
    '{4'b1010, 4'b0110, 8'd12, 4'd7},   // R7 lanes 0 and 3 idle
    '{4'b0011, 4'b1111, 8'd3,  4'd8},   // R8
    '{4'b1100, 4'b1111, 8'd2,  4'd8},
    '{4'b0110, 4'b1111, 8'd5,  4'd3}    // R3 mixed pattern
  };

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;

  logic [TAPS-1:0] mHist [LANES];
  int    qOut  [3][LANES];
  bit    qVal  [3][LANES];
  bit    qLive [3];
  string qTag  [3];

  function automatic string reqTag(input logic [3:0] r);
    case (r)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic int windowSum(input logic [TAPS-1:0] h);
    int s = 0;
    for (int i = 0; i < TAPS; i++) if (h[i]) s += W[i];
    return s;
  endfunction

  task automatic check(input string tag, input int lane, input int gotO, input bit gotV,
                       input int expO, input bit expV);
    checks++;
    if (gotO != expO || gotV != expV) begin
      fails++;
      $display("FAIL %s lane %0d: got sample=%0d valid=%0b, expected sample=%0d valid=%0b",
               tag, lane, gotO, gotV, expO, expV);
    end
  endtask

  task automatic step(input logic [3:0] b, input logic [3:0] v, input string tag);
    @(negedge clk);
    if (qLive[2])
      for (int l = 0; l < LANES; l++)
        check(qTag[2], l, int'(sampleOut[l*OUT_W +: OUT_W]), sampleValid[l], qOut[2][l], qVal[2][l]);
    for (int s = 2; s > 0; s--) begin
      qLive[s] = qLive[s-1];
      qTag[s]  = qTag[s-1];
      for (int l = 0; l < LANES; l++) begin
        qOut[s][l] = qOut[s-1][l];
        qVal[s][l] = qVal[s-1][l];
      end
    end
    bitIn    = b;
    bitValid = v;
    for (int l = 0; l < LANES; l++) begin
      if (v[l]) mHist[l] = {mHist[l][TAPS-2:0], b[l]};
      qOut[0][l] = (windowSum(mHist[l]) >> 2) & 255;
      qVal[0][l] = v[l];
    end
    qLive[0] = 1'b1;
    qTag[0]  = tag;
  endtask

  // R1: hold reset, check cleared outputs while still in reset, clear the model.
  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; bitIn = '0; bitValid = '0;
    repeat (3) @(negedge clk);
    for (int l = 0; l < LANES; l++)
      check("R1", l, int'(sampleOut[l*OUT_W +: OUT_W]), sampleValid[l], 0, 1'b0);
    rst = 1'b0;
    for (int l = 0; l < LANES; l++) mHist[l] = '0;
    for (int s = 0; s < 3; s++) qLive[s] = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion before timeout");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bitIn = '0; bitValid = '0;
    for (int s = 0; s < 3; s++) qLive[s] = 1'b0;
    doReset();

    // Vector table walk.
    for (int v = 0; v < NVEC; v++)
      for (int r = 0; r < int'(VECS[v].reps); r++)
        step(VECS[v].bits, VECS[v].valid, reqTag(VECS[v].req));

    // R2: isolated qualifier pulse; strobe and data appear three clocks later only.
    repeat (4) step(4'b0000, 4'b0000, "R2");
    step(4'b1111, 4'b1111, "R2");
    repeat (5) step(4'b0000, 4'b0000, "R2");

    // R9 and R1: reset in the middle of a run, then a short ramp from an empty history.
    repeat (10) step(4'b1111, 4'b1111, "R3");
    doReset();
    repeat (6) step(4'b1011, 4'b1111, "R9");
    repeat (4) step(4'b0000, 4'b0000, "R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule